// File: doc/BRIEF.md
# Keyed-Clear Watchdog Timer

This block is a watchdog timer mapped into a small 32-bit register space. It counts edges of a slow reference clock, which it first synchronizes into the bus clock domain. The edges pass through a fixed divide-by-32 stage and then into a main counter. The main counter expires after a power-of-two number of divided ticks, and the exponent of that power comes from a configuration input that is captured at reset. On expiry the block issues a one-cycle reset request on the bus clock. It also records the event in a status register that a normal reset does not clear.

Software keeps the system alive by writing a 16-bit service key into the upper half-word of the control register before the period runs out. Every register can be written directly, or through clear, set and invert alias addresses. Through an alias, each 1 in the write data acts on only that bit. A window option limits servicing to the last quarter of the period. A key written before that quarter counts as a fault and trips the watchdog at once.

Top module: `keyed_watchdog`

## Requirements
- R1: While the enable bit (control bit 15) is 0, the divider and the main counter stay at zero and no reset request is issued, however long the slow clock runs.
- R2: Reading the control register (offset 0x00) returns the enable bit at bit 15 and the window flag at bit 0. It also returns the clock-source code in bits 7:6 and the postscaler exponent in bits 12:8. These two fields are captured from the configuration inputs during reset, and writes through any alias do not change them. After reset, enable and window are 0.
- R3: With the watchdog enabled and not serviced, successive reset requests are exactly 32 × 2^P slow-clock rising edges apart, where P is the postscaler exponent.
- R4: A write to offset 0x00 with byte enables 4'b1100 and data bits 31:16 equal to 0x5743 restarts the count from zero. Other data in those bits does not restart it, and neither does the key value written with any other byte-enable pattern.
- R5: On expiry, rst_req is high for exactly one bus-clock cycle, and bit 4 of the status register (offset 0x10) is set.
- R6: The status bits are cleared only by por or by software writes. Asserting rst alone leaves them unchanged, but clears the enable and window bits.
- R7: If pwr_idle is high when a timeout occurs, status bit 2 is also set. If pwr_sleep is high, status bit 3 is also set.
- R8: Each register has aliases at base+0x4 (clear bits), base+0x8 (set bits) and base+0xC (invert bits). Only bits in bytes whose byte enable is 1 are affected. The control register is at base 0x00 and the status register at base 0x10.
- R9: While the window flag is 1, a valid key write accepted when the count is below term − max(term/4, 1) causes an immediate timeout. A key written inside the final quarter restarts the count normally.
- R10: The counter advances only on rising edges of slow_clk, after two synchronizer stages. A slow_clk held at a constant level never leads to a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous system reset, active high |
| por | input | 1 | Synchronous power-on reset, also clears status |
| slow_clk | input | 1 | Slow reference clock, asynchronous to clk |
| cfg_clksel | input | 2 | Clock-source code captured at reset |
| cfg_postscale | input | 5 | Postscaler exponent captured at reset |
| pwr_idle | input | 1 | System is in idle mode |
| pwr_sleep | input | 1 | System is in sleep mode |
| bus_valid | input | 1 | Write strobe qualifier |
| bus_write | input | 1 | 1 for a write access |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The period is measured three ways. It is measured between back-to-back unserviced timeouts for several randomly chosen postscaler exponents, which shows whether the power-of-two terminal and the fixed divider are both applied. It is measured from the last accepted key to the next timeout, which separates a genuine restart from a write that only looked like a key. It is also checked with the slow clock frozen, which separates edge counting from level counting. Random streams that mix correct keys, wrong keys and the key with the wrong byte enables show that only the exact half-word access restarts the count. Directed key writes placed early and late in a windowed period show the two outcomes of the window rule.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int unsigned DATA_W     = 32;
    localparam int unsigned BE_W       = DATA_W / 8;
    localparam int unsigned PS_W       = 5;
    localparam int unsigned CS_W       = 2;
    localparam int unsigned PRE_LOG2   = 5;

    localparam int unsigned EN_BIT     = 15;
    localparam int unsigned WIN_BIT    = 0;
    localparam int unsigned PS_LSB     = 8;
    localparam int unsigned CS_LSB     = 6;
    localparam int unsigned FLAG_IDLE  = 2;
    localparam int unsigned FLAG_SLEEP = 3;
    localparam int unsigned FLAG_TMO   = 4;

    localparam logic [15:0]       SERVICE_KEY = 16'h5743;
    localparam logic [BE_W-1:0]   KEY_BE      = 4'b1100;

    localparam logic [DATA_W-1:0] CTRL_WMASK =
        (DATA_W'(1) << EN_BIT) | (DATA_W'(1) << WIN_BIT);
    localparam logic [DATA_W-1:0] STAT_WMASK =
        (DATA_W'(1) << FLAG_TMO) | (DATA_W'(1) << FLAG_IDLE) | (DATA_W'(1) << FLAG_SLEEP);

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_CLR   = 2'd1,
        OP_SET   = 2'd2,
        OP_INV   = 2'd3
    } alias_op_e;

    typedef struct packed {
        logic              valid;
        logic              sel_stat;
        alias_op_e         op;
        logic [BE_W-1:0]   be;
        logic [DATA_W-1:0] data;
    } bus_req_t;

    function automatic logic [DATA_W-1:0] be_mask(input logic [BE_W-1:0] be);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < BE_W; i++) begin
            m[i*8 +: 8] = {8{be[i]}};
        end
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] apply_alias(
        input logic [DATA_W-1:0] cur,
        input logic [DATA_W-1:0] wd,
        input logic [DATA_W-1:0] m,
        input alias_op_e         op
    );
        case (op)
            OP_WRITE: return (cur & ~m) | (wd & m);
            OP_CLR:   return cur & ~(wd & m);
            OP_SET:   return cur | (wd & m);
            default:  return cur ^ (wd & m);
        endcase
    endfunction

endpackage

// File: rtl/wdt_tick_sync.sv
module wdt_tick_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic slow_clk,
    output logic tick
);
    logic [SYNC_STAGES:0] shift_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
        end else begin
            shift_q <= {shift_q[SYNC_STAGES-1:0], slow_clk};
        end
    end

    // rising edge seen after the synchronizer stages
    assign tick = shift_q[SYNC_STAGES-1] & ~shift_q[SYNC_STAGES];

    AST_TICK_ISOLATED: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);  // R10
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int unsigned PRE_W = PRE_LOG2,
    parameter int unsigned EXP_W = PS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             win,
    input  logic [EXP_W-1:0] ps,
    input  logic             tick,
    input  logic             key_hit,
    output logic             tmo
);
    localparam int unsigned CNT_W = 1 << EXP_W;

    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] term;
    logic [CNT_W-1:0] quarter;
    logic [CNT_W-1:0] win_lo;
    logic             pre_wrap;
    logic             tmo_count;
    logic             tmo_early;

    always_comb begin
        term      = CNT_W'(1) << ps;
        quarter   = ((term >> 2) == '0) ? CNT_W'(1) : (term >> 2);
        win_lo    = term - quarter;
        pre_wrap  = tick && (pre_q == '1);
        tmo_count = en && pre_wrap && (cnt_q == term - CNT_W'(1));
        tmo_early = en && key_hit && win && (cnt_q < win_lo);
        tmo       = tmo_count || tmo_early;
    end

    always_ff @(posedge clk) begin
        if (rst || !en || key_hit || tmo) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (tick) begin
            pre_q <= pre_q + PRE_W'(1);
            if (pre_wrap) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    AST_DISABLED_HELD: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt_q == '0 && pre_q == '0));  // R1
    AST_CNT_BELOW_TERM: assert property (@(posedge clk) disable iff (rst)
        en |-> (cnt_q < term));  // R3
    AST_KEY_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        key_hit |=> (cnt_q == '0 && pre_q == '0));  // R4
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              por,
    input  bus_req_t          req,
    input  logic              rd_stat,
    input  logic [CS_W-1:0]   cfg_clksel,
    input  logic [PS_W-1:0]   cfg_postscale,
    input  logic              pwr_idle,
    input  logic              pwr_sleep,
    input  logic              tmo,
    output logic [DATA_W-1:0] rdata,
    output logic              en,
    output logic              win,
    output logic [PS_W-1:0]   ps,
    output logic              key_hit,
    output logic              flag_tmo
);
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] stat_q;
    logic [DATA_W-1:0] stat_d;
    logic [DATA_W-1:0] ctrl_view;
    logic [CS_W-1:0]   cs_q;
    logic [PS_W-1:0]   ps_q;
    logic              ctrl_wr;
    logic              stat_wr;

    assign ctrl_wr = req.valid && !req.sel_stat;
    assign stat_wr = req.valid && req.sel_stat;
    assign key_hit = ctrl_wr && (req.op == OP_WRITE) && (req.be == KEY_BE)
                     && (req.data[DATA_W-1 -: 16] == SERVICE_KEY);

    always_ff @(posedge clk) begin
        if (rst || por) begin
            ctrl_q <= '0;
            cs_q   <= cfg_clksel;
            ps_q   <= cfg_postscale;
        end else if (ctrl_wr) begin
            ctrl_q <= apply_alias(ctrl_q, req.data, be_mask(req.be) & CTRL_WMASK, req.op);
        end
    end

    always_comb begin
        stat_d = stat_q;
        if (stat_wr) begin
            stat_d = apply_alias(stat_q, req.data, be_mask(req.be) & STAT_WMASK, req.op);
        end
        if (tmo) begin
            stat_d[FLAG_TMO] = 1'b1;
            if (pwr_idle)  stat_d[FLAG_IDLE]  = 1'b1;
            if (pwr_sleep) stat_d[FLAG_SLEEP] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (por) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign ctrl_view = ctrl_q
                     | (DATA_W'(ps_q) << PS_LSB)
                     | (DATA_W'(cs_q) << CS_LSB);
    assign rdata    = rd_stat ? stat_q : ctrl_view;
    assign en       = ctrl_q[EN_BIT];
    assign win      = ctrl_q[WIN_BIT];
    assign ps       = ps_q;
    assign flag_tmo = stat_q[FLAG_TMO];

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst || por)
        1'b1 |=> ($stable(ps_q) && $stable(cs_q)));  // R2
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (por)
        (stat_q[FLAG_TMO] && !stat_wr) |=> stat_q[FLAG_TMO]);  // R6
    AST_FLAG_ON_TMO: assert property (@(posedge clk) disable iff (por)
        tmo |=> stat_q[FLAG_TMO]);  // R5
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import wdt_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 por,
    input  logic                 slow_clk,
    input  logic [CS_W-1:0]      cfg_clksel,
    input  logic [PS_W-1:0]      cfg_postscale,
    input  logic                 pwr_idle,
    input  logic                 pwr_sleep,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [BE_W-1:0]      bus_be,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 rst_req
);
    localparam int unsigned DEC_LSB = 5;

    logic             any_rst;
    logic             tick;
    logic             en;
    logic             win;
    logic [PS_W-1:0]  ps;
    logic             key_hit;
    logic             tmo;
    logic             flag_tmo;
    bus_req_t         req;

    assign any_rst = rst || por;

    always_comb begin
        req.valid    = bus_valid && bus_write
                       && (bus_addr[ADDR_W-1:DEC_LSB] == '0)
                       && (bus_addr[1:0] == 2'b00);
        req.sel_stat = bus_addr[4];
        req.op       = alias_op_e'(bus_addr[3:2]);
        req.be       = bus_be;
        req.data     = bus_wdata;
    end

    wdt_tick_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst      (any_rst),
        .slow_clk (slow_clk),
        .tick     (tick)
    );

    wdt_regs u_regs (
        .clk           (clk),
        .rst           (rst),
        .por           (por),
        .req           (req),
        .rd_stat       (bus_addr[4]),
        .cfg_clksel    (cfg_clksel),
        .cfg_postscale (cfg_postscale),
        .pwr_idle      (pwr_idle),
        .pwr_sleep     (pwr_sleep),
        .tmo           (tmo),
        .rdata         (bus_rdata),
        .en            (en),
        .win           (win),
        .ps            (ps),
        .key_hit       (key_hit),
        .flag_tmo      (flag_tmo)
    );

    wdt_counter #(
        .PRE_W (PRE_LOG2),
        .EXP_W (PS_W)
    ) u_cnt (
        .clk     (clk),
        .rst     (any_rst),
        .en      (en),
        .win     (win),
        .ps      (ps),
        .tick    (tick),
        .key_hit (key_hit),
        .tmo     (tmo)
    );

    always_ff @(posedge clk) begin
        if (any_rst) begin
            rst_req <= 1'b0;
        end else begin
            rst_req <= tmo && !rst_req;
        end
    end

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (any_rst)
        rst_req |=> !rst_req);  // R5
    AST_REQ_FLAGGED: assert property (@(posedge clk) disable iff (any_rst)
        rst_req |-> flag_tmo);  // R5
    AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (any_rst)
        rst_req |-> $past(en));  // R1
endmodule

// File: tb/tb_keyed_watchdog.sv
module tb_keyed_watchdog;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        por = 1'b1;
    logic        slow_clk = 1'b0;
    logic [1:0]  cfg_clksel = 2'd2;
    logic [4:0]  cfg_postscale = 5'd3;
    logic        pwr_idle = 1'b0;
    logic        pwr_sleep = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [3:0]  bus_be = 4'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        rst_req;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int pulses = 0;
    int last_pulse = 0;
    int wide = 0;
    logic prev_req = 1'b0;
    logic slow_run = 1'b1;
    int slow_div = 0;

    keyed_watchdog dut (
        .clk(clk), .rst(rst), .por(por), .slow_clk(slow_clk),
        .cfg_clksel(cfg_clksel), .cfg_postscale(cfg_postscale),
        .pwr_idle(pwr_idle), .pwr_sleep(pwr_sleep),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rst_req(rst_req)
    );

    always #4 clk = ~clk;

    // slow clock: toggles every 2 bus cycles -> one rising edge per 4 cycles
    always @(negedge clk) begin
        if (slow_run) begin
            slow_div = slow_div + 1;
            if (slow_div == 2) begin
                slow_div = 0;
                slow_clk = ~slow_clk;
            end
        end
    end

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_req) begin
            pulses = pulses + 1;
            last_pulse = cyc;
            if (prev_req) wide = wide + 1;
        end
        prev_req = rst_req;
    end

    function automatic logic [31:0] exp_ctrl(input logic en, input logic win,
                                             input logic [4:0] ps, input logic [1:0] cs);
        return (32'(en) << 15) | (32'(ps) << 8) | (32'(cs) << 6) | 32'(win);
    endfunction

    function automatic int exp_period(input logic [4:0] ps);
        return 4 * 32 * (1 << ps);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_be = 4'h0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic key(input logic [15:0] k, input logic [3:0] be);
        bus_wr(8'h00, {k, 16'h8000}, be);
    endtask

    task automatic wait_pulses(input int target, input int limit);
        int start = cyc;
        while (pulses < target && (cyc - start) < limit) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic [4:0] ps, input logic with_por);
        @(negedge clk);
        cfg_postscale = ps;
        rst = 1'b1; por = with_por;
        idle(4);
        rst = 1'b0; por = 1'b0;
        idle(2);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int p0, t1, tk, seed;
        seed = $urandom(32'h5eed);

        do_reset(5'd3, 1'b1);
        bus_rd(8'h00, rd); chk("R2 ctrl after reset", rd, exp_ctrl(0, 0, 3, 2));
        bus_rd(8'h10, rd); chk("R6 status after por", rd, 32'h0);
        chk("R5 no request after reset", 32'(rst_req), 32'h0);

        // R1: disabled, slow clock running
        p0 = pulses;
        idle(3000);
        chk("R1 no request while disabled", 32'(pulses), 32'(p0));

        // R8 + R2: aliases and read-only fields
        bus_wr(8'h08, 32'h0000_1F00, 4'b1111);
        bus_rd(8'h00, rd); chk("R2 set alias ignores read-only", rd, exp_ctrl(0, 0, 3, 2));
        bus_wr(8'h08, 32'h0000_8000, 4'b1101);
        bus_rd(8'h00, rd); chk("R8 byte enable masks set", rd, exp_ctrl(0, 0, 3, 2));
        bus_wr(8'h08, 32'h0000_8000, 4'b0010);
        bus_rd(8'h00, rd); chk("R8 set alias enables", rd, exp_ctrl(1, 0, 3, 2));

        // R3/R5: free-running period
        p0 = pulses;
        wait_pulses(p0 + 1, 1300);
        t1 = last_pulse;
        bus_rd(8'h10, rd); chk("R5 status bit 4 set", rd & 32'h10, 32'h10);
        wait_pulses(p0 + 2, 1300);
        chk_rng("R3 period ps=3", last_pulse - t1, exp_period(3), exp_period(3));

        // R4: servicing with correct key keeps it quiet, random wrong keys mixed in
        p0 = pulses;
        for (int i = 0; i < 6; i++) begin
            key(16'h5743, 4'b1100);
            idle(150);
            key(16'(($urandom % 16'hFFFE) + 1) ^ 16'h5743, 4'b1100);
            idle(400);
        end
        tk = cyc;
        key(16'h5743, 4'b1100);
        chk("R4 correct key prevents timeout", 32'(pulses), 32'(p0));
        for (int i = 0; i < 4; i++) begin
            idle(200);
            if (i == 1) key(16'h5743, 4'b1111);
            else key(16'h5743 ^ 16'($urandom % 255 + 1), 4'b1100);
        end
        wait_pulses(p0 + 1, 1500);
        chk_rng("R4 wrong keys do not restart", last_pulse - tk, exp_period(3) - 8, exp_period(3) + 8);

        // R6: status survives rst, cleared by clear alias and por
        do_reset(5'd3, 1'b0);
        bus_rd(8'h10, rd); chk("R6 flag survives rst", rd & 32'h10, 32'h10);
        bus_rd(8'h00, rd); chk("R6 rst clears enable", rd, exp_ctrl(0, 0, 3, 2));
        bus_wr(8'h14, 32'h0000_0010, 4'b0001);
        bus_rd(8'h10, rd); chk("R8 clear alias on status", rd, 32'h0);
        bus_wr(8'h18, 32'h0000_0010, 4'b0001);
        bus_rd(8'h10, rd); chk("R8 set alias on status", rd, 32'h10);
        do_reset(5'd3, 1'b1);
        bus_rd(8'h10, rd); chk("R6 por clears status", rd, 32'h0);

        // R7: idle and sleep flags
        pwr_idle = 1'b1;
        bus_wr(8'h08, 32'h0000_8000, 4'b0010);
        p0 = pulses;
        wait_pulses(p0 + 1, 1300);
        idle(2);
        bus_rd(8'h10, rd); chk("R7 idle flag", rd, 32'h14);
        pwr_idle = 1'b0; pwr_sleep = 1'b1;
        bus_wr(8'h14, 32'h0000_001C, 4'b0001);
        wait_pulses(p0 + 2, 1300);
        idle(2);
        bus_rd(8'h10, rd); chk("R7 sleep flag", rd, 32'h18);
        pwr_sleep = 1'b0;

        // R8: invert alias
        bus_wr(8'h0C, 32'h0000_8000, 4'b0010);
        bus_rd(8'h00, rd); chk("R8 invert alias off", rd, exp_ctrl(0, 0, 3, 2));
        bus_wr(8'h0C, 32'h0000_8001, 4'b0011);
        bus_rd(8'h00, rd); chk("R8 invert alias on", rd, exp_ctrl(1, 1, 3, 2));

        // R9: window mode
        p0 = pulses;
        wait_pulses(p0 + 1, 1300);
        t1 = last_pulse;
        idle(200);
        tk = cyc;
        key(16'h5743, 4'b1100);
        wait_pulses(p0 + 2, 20);
        chk_rng("R9 early key trips", last_pulse - tk, 0, 3);
        t1 = last_pulse;
        while (cyc - t1 < 900) @(negedge clk);
        tk = cyc;
        key(16'h5743, 4'b1100);
        idle(400);
        chk("R9 late key accepted", 32'(pulses), 32'(p0 + 2));
        wait_pulses(p0 + 3, 1300);
        chk_rng("R9 period after late key", last_pulse - tk, exp_period(3) - 8, exp_period(3) + 8);
        bus_wr(8'h04, 32'h0000_0001, 4'b0001);

        // R10: frozen slow clock
        key(16'h5743, 4'b1100);
        slow_run = 1'b0;
        p0 = pulses;
        idle(3000);
        chk("R10 frozen slow clock never times out", 32'(pulses), 32'(p0));
        slow_run = 1'b1;

        // R3: random postscaler values
        for (int i = 0; i < 4; i++) begin
            logic [4:0] ps;
            ps = 5'(1 + ($urandom % 3));
            do_reset(ps, 1'b0);
            bus_rd(8'h00, rd); chk("R2 postscale captured", rd, exp_ctrl(0, 0, ps, 2));
            bus_wr(8'h08, 32'h0000_8000, 4'b0010);
            p0 = pulses;
            wait_pulses(p0 + 1, exp_period(ps) + 300);
            t1 = last_pulse;
            wait_pulses(p0 + 2, exp_period(ps) + 300);
            chk_rng("R3 random period", last_pulse - t1, exp_period(ps), exp_period(ps));
        end

        chk("R5 every request one cycle wide", 32'(wide), 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule